// File: doc/BRIEF.md
# Block Address Translation Unit

This block maps large, naturally aligned regions of the effective address space onto physical memory without a page-table walk. It keeps two small banks of translation pairs, one consulted by instruction fetches and one by data accesses. Each pair has an upper word that describes the effective block and who may use it, and a lower word that supplies the physical block, the cache attributes and the access rights.

Software loads the pairs one 32-bit word at a time through a synchronous write port. Each lookup port is purely combinational. It compares an effective address against every pair in its bank. The lowest-numbered pair that is valid for the current privilege state wins. The port then returns a hit flag, a 36-bit physical address, four cache attribute bits and a protection-fault flag. Instruction fetches are always treated as reads.

Top module: `blk_xlate`

## Requirements
- R1: After reset every pair in both banks is zero, so every lookup on either port misses.
- R2: A write with `cfg_we_i` high stores `cfg_data_i` at the next rising clock edge. It goes into bank `cfg_dside_i` (1 = data, 0 = instruction), pair `cfg_idx_i`, and the upper word when `cfg_upper_i` is 1, otherwise the lower word. Upper word layout: bits 31:17 are the effective block index, bits 12:2 the length mask, bit 1 supervisor-valid and bit 0 user-valid.
- R3: A pair matches when effective address bits 31:17 equal the stored block index at every position whose length-mask bit is clear. Mask bit k (upper word bit 2+k) covers address bit 17+k. All zeros gives a 128 KB block and each further low-order one doubles it. With the default `EXT_LEN=0`, upper word bits 16:13 are ignored. With `EXT_LEN=1` they extend the mask to address bit 31.
- R4: In supervisor state (`*_sup_i`=1) a pair takes part only if its supervisor-valid bit is set. In user state it takes part only if its user-valid bit is set.
- R5: On a hit the physical address is formed as follows:
  - bits 35:33 come from lower word bits 11:9;
  - bit 32 comes from lower word bit 2;
  - bits 31:17 take the lower word's block index where the mask is clear and the effective address where it is set;
  - bits 16:0 equal the effective address.
- R6: On a hit, `*_attr_o` is {write-through, cache-inhibit, coherent, guarded}, taken from lower word bits 6, 5, 4 and 3 in that order, with write-through as the MSB.
- R7: The lower word bits 1:0 are the protection code. 00 faults on any access. 01 and 11 are read-only and fault on a write. 10 never faults. A faulting access still reports the hit and the translation.
- R8: When several pairs match, the lowest-numbered one supplies every output.
- R9: With no matching pair, hit, physical address, attributes and fault are all zero.
- R10: The guarded bit (lower word bit 3) is stored as zero in instruction-bank pairs. Instruction fetches are checked as reads.
- R11: Writes to one bank do not change lookups on the other bank's port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Word write strobe |
| cfg_dside_i | input | 1 | Bank select: 1 data, 0 instruction |
| cfg_upper_i | input | 1 | 1 upper word, 0 lower word |
| cfg_idx_i | input | IDX_W | Pair index (2 bits by default) |
| cfg_data_i | input | 32 | Word to store |
| if_ea_i | input | 32 | Fetch effective address |
| if_sup_i | input | 1 | Fetch privilege: 1 supervisor |
| if_hit_o | output | 1 | Fetch translation found |
| if_pa_o | output | 36 | Fetch physical address |
| if_attr_o | output | 4 | Fetch cache attributes |
| if_fault_o | output | 1 | Fetch protection fault |
| dt_ea_i | input | 32 | Data effective address |
| dt_sup_i | input | 1 | Data privilege: 1 supervisor |
| dt_wr_i | input | 1 | Data access is a write |
| dt_hit_o | output | 1 | Data translation found |
| dt_pa_o | output | 36 | Data physical address |
| dt_attr_o | output | 4 | Data cache attributes |
| dt_fault_o | output | 1 | Data protection fault |

## Verification
The bench aims at the edges of the length mask. An address that differs from the block index only inside the masked span must hit, and one that differs one bit above it must miss. A compare that ignored the mask, or masked one position too many, would turn one of these into the wrong outcome. The bench also sets upper word bits 16:13 in the default build and requires them to be ignored. A design that honoured them would hit on addresses far outside the block. Finally, it overlaps pairs, flips the privilege valid bits, uses every protection code for both reads and writes, and sets the physical extension bits and the guarded bit in the instruction bank. A wrong winner, a swapped valid bit, a fault that hides the hit, or misplaced high address bits would each show up as a wrong value on the outputs.

// File: rtl/blk_xlate_pkg.sv
`timescale 1ns/1ps
package blk_xlate_pkg;
  localparam int WORD_W     = 32;
  localparam int PA_W       = 36;
  localparam int BLK_W      = 15;  // effective address bits 31:17
  localparam int OFS_W      = 17;
  localparam int BASE_LEN_W = 11;
  localparam int ATTR_W     = 4;
  localparam int GUARD_BIT  = 3;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } bx_pair_t;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_RO   = 2'b01,
    PROT_RW   = 2'b10,
    PROT_RO2  = 2'b11
  } bx_prot_e;
endpackage

// File: rtl/bx_bank.sv
`timescale 1ns/1ps
module bx_bank
  import blk_xlate_pkg::*;
#(
  parameter int N        = 4,
  parameter bit NO_GUARD = 1'b0,
  localparam int IDX_W   = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               upper_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [WORD_W-1:0]  data_i,
  output bx_pair_t [N-1:0]   pairs_o
);
  localparam logic [WORD_W-1:0] LO_KEEP =
    NO_GUARD ? ~(WORD_W'(1) << GUARD_BIT) : '1;

  for (genvar e = 0; e < N; e++) begin : g_pair
    logic sel;
    assign sel = we_i && (idx_i == IDX_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pairs_o[e] <= '0;
      end else if (sel) begin
        if (upper_i) pairs_o[e].hi <= data_i;
        else         pairs_o[e].lo <= data_i & LO_KEEP;
      end
    end
  end
endmodule

// File: rtl/bx_match.sv
`timescale 1ns/1ps
module bx_match
  import blk_xlate_pkg::*;
#(
  parameter bit EXT_LEN = 1'b0
) (
  input  bx_pair_t           pair_i,
  input  logic [WORD_W-1:0]  ea_i,
  input  logic               sup_i,
  output logic               match_o,
  output logic [PA_W-1:0]    pa_o
);
  localparam int LEN_W = EXT_LEN ? BLK_W : BASE_LEN_W;

  logic [BLK_W-1:0] len_mask, ea_blk, eff_idx, phys_idx;
  logic             valid;
  logic             unused_bits;

  assign unused_bits = ^{pair_i.hi, pair_i.lo};

  always_comb begin
    len_mask              = '0;
    len_mask[LEN_W-1:0]   = pair_i.hi[2 +: LEN_W];
    ea_blk                = ea_i[WORD_W-1:OFS_W];
    eff_idx               = pair_i.hi[WORD_W-1:OFS_W];
    phys_idx              = pair_i.lo[WORD_W-1:OFS_W];
    valid                 = sup_i ? pair_i.hi[1] : pair_i.hi[0];
    match_o               = valid && (((ea_blk ^ eff_idx) & ~len_mask) == '0);
    pa_o = {pair_i.lo[11:9], pair_i.lo[2],
            (phys_idx & ~len_mask) | (ea_blk & len_mask),
            ea_i[OFS_W-1:0]};
  end
endmodule

// File: rtl/bx_lookup.sv
`timescale 1ns/1ps
module bx_lookup
  import blk_xlate_pkg::*;
#(
  parameter int N       = 4,
  parameter bit EXT_LEN = 1'b0,
  localparam int IDX_W  = $clog2(N)
) (
  input  bx_pair_t [N-1:0]   pairs_i,
  input  logic [WORD_W-1:0]  ea_i,
  input  logic               sup_i,
  input  logic               wr_i,
  output logic               hit_o,
  output logic [PA_W-1:0]    pa_o,
  output logic [ATTR_W-1:0]  attr_o,
  output logic               fault_o
);
  logic [N-1:0]    match;
  logic [PA_W-1:0] pa_each [N];
  logic [IDX_W-1:0] win;
  logic            any;
  bx_pair_t        sel;
  bx_prot_e        prot;
  logic            unused_sel;

  for (genvar e = 0; e < N; e++) begin : g_cmp
    bx_match #(.EXT_LEN(EXT_LEN)) u_match (
      .pair_i  (pairs_i[e]),
      .ea_i    (ea_i),
      .sup_i   (sup_i),
      .match_o (match[e]),
      .pa_o    (pa_each[e])
    );
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    win = '0;
    any = 1'b0;
    for (int e = N - 1; e >= 0; e--) begin
      if (match[e]) begin
        win = IDX_W'(e);
        any = 1'b1;
      end
    end
  end

  assign sel        = pairs_i[win];
  assign prot       = bx_prot_e'(sel.lo[1:0]);
  assign unused_sel = ^{sel.hi, sel.lo};

  always_comb begin
    hit_o   = any;
    pa_o    = '0;
    attr_o  = '0;
    fault_o = 1'b0;
    if (any) begin
      pa_o    = pa_each[win];
      attr_o  = sel.lo[6:3];
      unique case (prot)
        PROT_NONE: fault_o = 1'b1;
        PROT_RW:   fault_o = 1'b0;
        default:   fault_o = wr_i;
      endcase
    end
  end
endmodule

// File: rtl/blk_xlate.sv
`timescale 1ns/1ps
module blk_xlate
  import blk_xlate_pkg::*;
#(
  parameter bit WIDE_BANK = 1'b0,
  parameter bit EXT_LEN   = 1'b0,
  localparam int N        = WIDE_BANK ? 8 : 4,
  localparam int IDX_W    = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_dside_i,
  input  logic              cfg_upper_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [31:0]       cfg_data_i,
  input  logic [31:0]       if_ea_i,
  input  logic              if_sup_i,
  output logic              if_hit_o,
  output logic [35:0]       if_pa_o,
  output logic [3:0]        if_attr_o,
  output logic              if_fault_o,
  input  logic [31:0]       dt_ea_i,
  input  logic              dt_sup_i,
  input  logic              dt_wr_i,
  output logic              dt_hit_o,
  output logic [35:0]       dt_pa_o,
  output logic [3:0]        dt_attr_o,
  output logic              dt_fault_o
);
  bx_pair_t [N-1:0] if_pairs, dt_pairs;

  bx_bank #(.N(N), .NO_GUARD(1'b1)) u_if_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && !cfg_dside_i),
    .upper_i (cfg_upper_i),
    .idx_i   (cfg_idx_i),
    .data_i  (cfg_data_i),
    .pairs_o (if_pairs)
  );

  bx_bank #(.N(N), .NO_GUARD(1'b0)) u_dt_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i && cfg_dside_i),
    .upper_i (cfg_upper_i),
    .idx_i   (cfg_idx_i),
    .data_i  (cfg_data_i),
    .pairs_o (dt_pairs)
  );

  bx_lookup #(.N(N), .EXT_LEN(EXT_LEN)) u_if_lookup (
    .pairs_i (if_pairs),
    .ea_i    (if_ea_i),
    .sup_i   (if_sup_i),
    .wr_i    (1'b0),
    .hit_o   (if_hit_o),
    .pa_o    (if_pa_o),
    .attr_o  (if_attr_o),
    .fault_o (if_fault_o)
  );

  bx_lookup #(.N(N), .EXT_LEN(EXT_LEN)) u_dt_lookup (
    .pairs_i (dt_pairs),
    .ea_i    (dt_ea_i),
    .sup_i   (dt_sup_i),
    .wr_i    (dt_wr_i),
    .hit_o   (dt_hit_o),
    .pa_o    (dt_pa_o),
    .attr_o  (dt_attr_o),
    .fault_o (dt_fault_o)
  );
endmodule

// File: rtl/blk_xlate_chk.sv
`timescale 1ns/1ps
module blk_xlate_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] if_ea_i,
  input logic        if_hit_o,
  input logic [35:0] if_pa_o,
  input logic [3:0]  if_attr_o,
  input logic        if_fault_o,
  input logic [31:0] dt_ea_i,
  input logic        dt_hit_o,
  input logic [35:0] dt_pa_o,
  input logic [3:0]  dt_attr_o,
  input logic        dt_fault_o
);
  AST_DT_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dt_hit_o |-> (dt_pa_o == '0 && dt_attr_o == '0 && !dt_fault_o)); // R9
  AST_IF_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_hit_o |-> (if_pa_o == '0 && if_attr_o == '0 && !if_fault_o)); // R9
  AST_IF_NO_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !if_attr_o[0]); // R10
  AST_DT_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_hit_o |-> dt_pa_o[16:0] == dt_ea_i[16:0]); // R5
  AST_IF_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    if_hit_o |-> if_pa_o[16:0] == if_ea_i[16:0]); // R5
  AST_FAULT_WITH_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dt_fault_o |-> dt_hit_o); // R7
  AST_RESET_EMPTY: assert property (@(posedge clk_i)
    !rst_ni |=> (!dt_hit_o && !if_hit_o) || !rst_ni); // R1
endmodule

bind blk_xlate blk_xlate_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .if_ea_i    (if_ea_i),
  .if_hit_o   (if_hit_o),
  .if_pa_o    (if_pa_o),
  .if_attr_o  (if_attr_o),
  .if_fault_o (if_fault_o),
  .dt_ea_i    (dt_ea_i),
  .dt_hit_o   (dt_hit_o),
  .dt_pa_o    (dt_pa_o),
  .dt_attr_o  (dt_attr_o),
  .dt_fault_o (dt_fault_o)
);

// File: tb/blk_xlate_test.sv
`timescale 1ns/1ps
module blk_xlate_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0, cfg_dside = 1'b0, cfg_upper = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic [31:0] if_ea = '0, dt_ea = '0;
  logic        if_sup = 1'b0, dt_sup = 1'b0, dt_wr = 1'b0;
  logic        if_hit, dt_hit, if_fault, dt_fault;
  logic [35:0] if_pa, dt_pa;
  logic [3:0]  if_attr, dt_attr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [31:0] m_hi [2][4];
  logic [31:0] m_lo [2][4];

  always #5 clk = ~clk;

  blk_xlate uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_dside_i(cfg_dside), .cfg_upper_i(cfg_upper),
    .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
    .if_ea_i(if_ea), .if_sup_i(if_sup),
    .if_hit_o(if_hit), .if_pa_o(if_pa), .if_attr_o(if_attr), .if_fault_o(if_fault),
    .dt_ea_i(dt_ea), .dt_sup_i(dt_sup), .dt_wr_i(dt_wr),
    .dt_hit_o(dt_hit), .dt_pa_o(dt_pa), .dt_attr_o(dt_attr), .dt_fault_o(dt_fault)
  );

  function automatic logic [31:0] mk_hi(logic [14:0] blk, logic [10:0] len, logic vs, logic vp);
    return {blk, 4'b0, len, vs, vp};
  endfunction

  function automatic logic [31:0] mk_lo(logic [14:0] blk, logic [2:0] ext, logic x32,
                                        logic [3:0] wimg, logic [1:0] pp);
    return {blk, 5'b0, ext, 2'b0, wimg, x32, pp};
  endfunction

  // expected {hit, pa, attr, fault} from the requirements
  function automatic logic [41:0] model(bit dside, logic [31:0] ea, bit sup, bit wr);
    for (int e = 0; e < 4; e++) begin
      logic [31:0] hi, lo;
      logic [14:0] msk, pblk;
      logic        v, flt;
      hi  = m_hi[dside][e];
      lo  = m_lo[dside][e];
      msk = {4'b0, hi[12:2]};
      v   = sup ? hi[1] : hi[0];
      if (v && (((ea[31:17] ^ hi[31:17]) & ~msk) == 15'd0)) begin
        pblk = (lo[31:17] & ~msk) | (ea[31:17] & msk);
        flt  = (lo[1:0] == 2'b00) || (wr && lo[1:0] != 2'b10);
        return {1'b1, lo[11:9], lo[2], pblk, ea[16:0], lo[6:3], flt};
      end
    end
    return '0;
  endfunction

  task automatic cfg_write(bit dside, int idx, bit upper, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dside = dside; cfg_idx = idx[1:0];
    cfg_upper = upper; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (upper) m_hi[dside][idx] = d;
    else       m_lo[dside][idx] = dside ? d : (d & ~32'h8);
  endtask

  task automatic look(bit dside, logic [31:0] ea, bit sup, bit wr, string req);
    logic [41:0] act, exp;
    if (dside) begin dt_ea = ea; dt_sup = sup; dt_wr = wr; end
    else       begin if_ea = ea; if_sup = sup; end
    #1;
    exp = model(dside, ea, sup, dside ? wr : 1'b0);
    act = dside ? {dt_hit, dt_pa, dt_attr, dt_fault} : {if_hit, if_pa, if_attr, if_fault};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s side=%0d ea=%h actual=%h expected=%h", req, dside, ea, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired R1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 4; e++) begin m_hi[s][e] = '0; m_lo[s][e] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: empty after reset
    look(1, 32'h0000_0000, 1, 0, "R1");
    look(0, 32'h0000_0000, 0, 0, "R1");
    look(1, 32'hFFFF_FFFF, 0, 1, "R1");

    // R2 R4: supervisor-only 128 KB block in data pair 0
    cfg_write(1, 0, 1, mk_hi(15'h0A5, 11'h000, 1'b1, 1'b0));
    cfg_write(1, 0, 0, mk_lo(15'h123, 3'd0, 1'b0, 4'b1000, 2'b10));
    look(1, {15'h0A5, 17'h1_2345}, 1, 0, "R2");
    look(1, {15'h0A5, 17'h0_0001}, 0, 0, "R4");
    look(1, {15'h0A4, 17'h0_0001}, 1, 0, "R9");
    // R11: instruction port unaffected
    look(0, {15'h0A5, 17'h1_2345}, 1, 0, "R11");

    // R3: 1 MB block (mask 0x007 -> address bits 19:17 masked)
    cfg_write(1, 1, 1, mk_hi(15'h200, 11'h007, 1'b1, 1'b1));
    cfg_write(1, 1, 0, mk_lo(15'h7F0, 3'd0, 1'b0, 4'b0100, 2'b10));
    look(1, {15'h204, 17'h0_0ABC}, 0, 0, "R3");
    look(1, {15'h207, 17'h1_FFFF}, 1, 1, "R3");
    look(1, {15'h208, 17'h0_0000}, 0, 0, "R3");

    // R3: bits 16:13 of the upper word ignored in the default build
    cfg_write(1, 2, 1, mk_hi(15'h011, 11'h000, 1'b1, 1'b1) | 32'h0001_E000);
    cfg_write(1, 2, 0, mk_lo(15'h055, 3'd0, 1'b0, 4'b0000, 2'b10));
    look(1, {15'h011, 17'h0_0010}, 1, 0, "R3");
    look(1, {15'h411, 17'h0_0010}, 1, 0, "R3");

    // R5 R6: high physical bits and attribute order
    cfg_write(1, 3, 1, mk_hi(15'h300, 11'h001, 1'b0, 1'b1));
    cfg_write(1, 3, 0, mk_lo(15'h1AA, 3'b101, 1'b1, 4'b1011, 2'b10));
    look(1, {15'h301, 17'h0_F0F0}, 0, 0, "R5");
    look(1, {15'h300, 17'h1_0001}, 0, 1, "R6");

    // R7: every protection code, read and write
    for (int pp = 0; pp < 4; pp++) begin
      cfg_write(1, 3, 0, mk_lo(15'h1AA, 3'b000, 1'b0, 4'b0001, pp[1:0]));
      look(1, {15'h300, 17'h0_0040}, 0, 0, "R7");
      look(1, {15'h300, 17'h0_0040}, 0, 1, "R7");
    end

    // R8: overlapping pairs 1 and 3, lower index wins
    cfg_write(1, 3, 1, mk_hi(15'h204, 11'h000, 1'b1, 1'b1));
    cfg_write(1, 3, 0, mk_lo(15'h0EE, 3'b011, 1'b1, 4'b0010, 2'b00));
    look(1, {15'h204, 17'h0_0100}, 1, 1, "R8");
    cfg_write(1, 1, 1, 32'h0);
    look(1, {15'h204, 17'h0_0100}, 1, 1, "R8");

    // R10: instruction guarded bit dropped, fetch is a read
    cfg_write(0, 2, 1, mk_hi(15'h050, 11'h003, 1'b1, 1'b1));
    cfg_write(0, 2, 0, mk_lo(15'h060, 3'b010, 1'b0, 4'b1111, 2'b01));
    look(0, {15'h052, 17'h0_4444}, 0, 0, "R10");
    look(0, {15'h050, 17'h0_0000}, 1, 0, "R10");
    // R11: data lookup at same address sees only data pairs
    look(1, {15'h052, 17'h0_4444}, 0, 0, "R11");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit          side;
      int          idx;
      logic [31:0] ea, h;
      logic [14:0] flip;
      side = 1'($urandom);
      idx  = $urandom % 4;
      if ($urandom % 6 == 0) begin
        logic [10:0] len;
        len = 11'((32'h1 << ($urandom % 12)) - 1);
        cfg_write(side, idx, 1, {15'($urandom), 4'($urandom), len, 2'($urandom)});
        cfg_write(side, idx, 0, $urandom);
      end
      h    = m_hi[side][$urandom % 4];
      flip = ($urandom % 3 == 0) ? 15'(32'h1 << ($urandom % 15)) : 15'd0;
      ea   = {h[31:17] ^ flip, 17'($urandom)};
      @(negedge clk);
      look(side, ea, 1'($urandom), 1'($urandom), side ? "R5" : "R3");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule